// File: doc/BRIEF.md
# Dual Timer with Interrupt Unit

This peripheral holds two independent down-counting timer channels and one shared interrupt unit. Both sit behind a simple 32-bit register port with byte offsets. Each channel has three registers: a reload value, a read-only live count and a control word. The control word picks an operation (load, hold or run) and a tick source. Four single-cycle tick-enable inputs stand in for the reference clocks. A channel in run mode steps down once for each pulse on its selected tick input. When the count is zero on such a tick, the channel reloads from its reload register and reports an expiry.

The interrupt unit latches one pending flag per channel. Software masks these flags and clears them by writing ones to an acknowledge offset. The single active-high interrupt line is the OR of the flags that are both pending and enabled. Reads take effect in the same cycle as the request. Writes take effect at the clock edge.

Top module: `dual_tick_timer`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears both counts, both reload registers, both control words (operation 0, source 0), the pending flags and the mask, so irq_o is low.
- R2: Channel c (c = 0 or 1) decodes its reload register at offset 0x10*c + 0x00, its live count (read-only) at 0x10*c + 0x04 and its control word at 0x10*c + 0x08. The reload and control registers read back what was written, with the control word keeping only bits [4:0].
- R3: Control bits [1:0] are the operation. Writing 0 (load) copies the reload register into the count, and the new count is readable after that write's clock edge. Operations 0, 1 (hold) and 3 (illegal) all leave the count frozen.
- R4: With operation 2 (run), each pulse on the selected tick input lowers the count by one. A pulse that finds the count at 0 instead reloads the reload value and sets the channel's pending bit (bit 0 for channel 0, bit 1 for channel 1). The period is therefore reload+1 ticks.
- R5: Control bits [4:2] are the tick source. Codes 4, 5, 6 and 7 select ticks_i[0], ticks_i[1], ticks_i[2] and ticks_i[3]. Codes 0 to 3 select nothing, and the count does not advance. Pulses on tick inputs that are not selected have no effect.
- R6: Writing a reload register leaves the live count unchanged. The new value is used at the next load operation or the next reload on expiry.
- R7: A write to offset 0x4C clears each pending bit whose data bit is 1. The acknowledge value is not stored: offset 0x4C reads 0, and a later expiry sets the bit again.
- R8: Offset 0x48 is the mask (bits [1:0], read/write). Offset 0x50 reads the pending bits. Offset 0x54 reads pending AND mask. irq_o is high exactly when that masked value is nonzero.
- R9: When an expiry and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R10: Reads of any other offset return 0. Writes to them change no register.
- R11: The channels are independent. Ticks, expiries and register writes of one channel do not change the other channel's count or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle of a read, else 0 |
| ticks_i | input | N_TICK | Single-cycle tick enables, one per reference source |
| irq_o | output | 1 | Interrupt, high while any pending and enabled flag is set |

## Verification
The hardest case to reach from the ports is an expiry and an acknowledge of the same bit landing in the same clock cycle. The bench sets a channel's reload value to zero and puts it in run mode, so every selected tick expires. It then raises that tick in the very cycle it issues the acknowledge write and checks that the pending bit survives. The reload arithmetic is covered by a sweep over both channels, all four sources and reload values 0 to 3. In that sweep the count is compared with a bench model after each selected pulse and after each pulse on an unselected input.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  typedef struct packed {
    logic [2:0] src;
    op_e        op;
  } ctrl_t;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned N_CH     = 2;
  localparam int unsigned SRC_BASE = 4;

  localparam logic [7:0] OFF_DIV    = 8'h00;
  localparam logic [7:0] OFF_DATA   = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam int unsigned CH_STRIDE = 16;
  localparam logic [7:0] OFF_MASK   = 8'h48;
  localparam logic [7:0] OFF_ACK    = 8'h4C;
  localparam logic [7:0] OFF_RAW    = 8'h50;
  localparam logic [7:0] OFF_MASKED = 8'h54;
endpackage

// File: rtl/dtt_counter.sv
module dtt_counter
  import dtt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_TICK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_we_i,
  input  logic [CNT_W-1:0]  div_wdata_i,
  input  logic              ctrl_we_i,
  input  logic [4:0]        ctrl_wdata_i,
  input  logic [N_TICK-1:0] ticks_i,
  output logic [CNT_W-1:0]  div_o,
  output logic [4:0]        ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              expire_o
);
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_new;
  logic [CNT_W-1:0] div_q, cnt_q;
  logic             tick_sel, step;

  // source codes below SRC_BASE select nothing
  always_comb begin
    tick_sel = 1'b0;
    for (int i = 0; i < N_TICK; i++) begin
      if (ctrl_q.src == 3'(SRC_BASE + i)) tick_sel = ticks_i[i];
    end
  end

  assign ctrl_new = ctrl_t'(ctrl_wdata_i);
  // a control write owns the cycle; no tick is counted in it
  assign step     = (ctrl_q.op == OP_RUN) && tick_sel && !ctrl_we_i;
  assign expire_o = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (div_we_i) div_q <= div_wdata_i;
      if (ctrl_we_i) begin
        ctrl_q <= ctrl_new;
        if (ctrl_new.op == OP_LOAD) cnt_q <= div_q;
      end else if (step) begin
        cnt_q <= (cnt_q == '0) ? div_q : cnt_q - 1'b1;
      end
    end
  end

  assign div_o  = div_q;
  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
  parameter int unsigned N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] expire_i,
  input  logic            mask_we_i,
  input  logic            ack_we_i,
  input  logic [N_CH-1:0] wdata_i,
  output logic [N_CH-1:0] raw_o,
  output logic [N_CH-1:0] mask_o,
  output logic            irq_o
);
  logic [N_CH-1:0] raw_q, mask_q, clr;

  assign clr = ack_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      // set after clear: a same-cycle expiry survives its acknowledge
      raw_q <= (raw_q & ~clr) | expire_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_TICK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_TICK-1:0] ticks_i,
  output logic              irq_o
);
  logic                        wr, rd;
  logic [N_CH-1:0][CNT_W-1:0]  div_w, cnt_w;
  logic [N_CH-1:0][4:0]        ctrl_w;
  logic [N_CH-1:0]             expire_w, raw_w, mask_w;
  logic [31:0]                 rdata;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam logic [7:0] BASE = 8'(ch * CH_STRIDE);
    dtt_counter #(
      .CNT_W (CNT_W),
      .N_TICK(N_TICK)
    ) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .div_we_i    (wr && addr_i == BASE + OFF_DIV),
      .div_wdata_i (wdata_i[CNT_W-1:0]),
      .ctrl_we_i   (wr && addr_i == BASE + OFF_CTRL),
      .ctrl_wdata_i(wdata_i[4:0]),
      .ticks_i     (ticks_i),
      .div_o       (div_w[ch]),
      .ctrl_o      (ctrl_w[ch]),
      .cnt_o       (cnt_w[ch]),
      .expire_o    (expire_w[ch])
    );
  end

  dtt_irq #(.N_CH(N_CH)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire_w),
    .mask_we_i(wr && addr_i == OFF_MASK),
    .ack_we_i (wr && addr_i == OFF_ACK),
    .wdata_i  (wdata_i[N_CH-1:0]),
    .raw_o    (raw_w),
    .mask_o   (mask_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata = '0;
    if (rd) begin
      for (int ch = 0; ch < N_CH; ch++) begin
        if (addr_i == 8'(ch * CH_STRIDE) + OFF_DIV)  rdata = 32'(div_w[ch]);
        if (addr_i == 8'(ch * CH_STRIDE) + OFF_DATA) rdata = 32'(cnt_w[ch]);
        if (addr_i == 8'(ch * CH_STRIDE) + OFF_CTRL) rdata = 32'(ctrl_w[ch]);
      end
      if (addr_i == OFF_MASK)   rdata = 32'(mask_w);
      if (addr_i == OFF_RAW)    rdata = 32'(raw_w);
      if (addr_i == OFF_MASKED) rdata = 32'(raw_w & mask_w);
    end
  end

  assign rdata_o = rdata;
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker
  import dtt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [7:0]                 addr_i,
  input logic [N_CH-1:0]            wdata_i,
  input logic [N_CH-1:0][CNT_W-1:0] cnt_w,
  input logic [N_CH-1:0][4:0]       ctrl_w,
  input logic [N_CH-1:0]            expire_w,
  input logic [N_CH-1:0]            raw_w
);
  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    logic ctrl_wr, ack_wr;
    assign ctrl_wr = req_i && we_i && addr_i == 8'(c * CH_STRIDE) + OFF_CTRL;
    assign ack_wr  = req_i && we_i && addr_i == OFF_ACK && wdata_i[c];

    // R4
    expire_sets_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_w[c] |=> raw_w[c]);

    // R4
    pending_needs_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(raw_w[c]) |-> $past(expire_w[c]));

    // R7
    ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_wr && !expire_w[c]) |=> !raw_w[c]);

    // R3
    not_run_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_w[c][1:0] != 2'd2 && !ctrl_wr) |=> $stable(cnt_w[c]));

    // R5
    no_source_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_w[c][4:2] < 3'd4 && !ctrl_wr) |=> $stable(cnt_w[c]));
  end
endmodule

bind dual_tick_timer dtt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i[1:0]),
  .cnt_w   (cnt_w),
  .ctrl_w  (ctrl_w),
  .expire_w(expire_w),
  .raw_w   (raw_w)
);

// File: tb/tb_dual_tick_timer.sv
`timescale 1ns/1ps
module tb_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  ticks = '0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_tick_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ticks_i(ticks), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", r, got, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    ticks[i] = 1'b1;
    @(negedge clk);
    ticks = '0;
  endtask

  task automatic rchk(input string r, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    br(a, v);
    chk(r, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rchk("R1 cnt0", 8'h04, 0);
    rchk("R1 cnt1", 8'h14, 0);
    rchk("R1 raw", 8'h50, 0);
    rchk("R1 mask", 8'h48, 0);
    rchk("R1 ctrl0", 8'h08, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 register map, R10 unmapped
    bw(8'h00, 32'h1234);
    bw(8'h10, 32'h55AA);
    bw(8'h18, 32'hFFFF_FFF1);
    rchk("R2 div0", 8'h00, 32'h1234);
    rchk("R2 div1", 8'h10, 32'h55AA);
    rchk("R2 ctrl1", 8'h18, 32'h11);
    rchk("R2 cnt1 untouched", 8'h14, 0);
    bw(8'h20, 32'hFFFF_FFFF);
    bw(8'h3C, 32'hFFFF_FFFF);
    bw(8'h58, 32'hFFFF_FFFF);
    rchk("R10 rd 0x20", 8'h20, 0);
    rchk("R10 rd 0x3C", 8'h3C, 0);
    rchk("R10 rd 0x0C", 8'h0C, 0);
    rchk("R10 div0 kept", 8'h00, 32'h1234);
    rchk("R10 mask kept", 8'h48, 0);
    rchk("R10 raw kept", 8'h50, 0);
    bw(8'h18, 32'h1);

    // R4/R5/R3/R11 sweep
    for (int ch = 0; ch < 2; ch++) begin
      for (int src = 4; src < 8; src++) begin
        for (int dv = 0; dv < 4; dv++) begin
          logic [7:0] b;
          int exp, nexp, oth;
          b = 8'(ch * 16);
          oth = (src - 4 + 1) % 4;
          bw(b, 32'(dv));
          bw(b + 8'h08, 32'((src << 2) | 0));
          rchk("R3 load", b + 8'h04, 32'(dv));
          bw(b + 8'h08, 32'((src << 2) | 2));
          bw(8'h4C, 32'h3);
          exp = dv; nexp = 0;
          for (int k = 0; k < 2 * (dv + 1); k++) begin
            pulse(oth);
            rchk("R5 unselected", b + 8'h04, 32'(exp));
            pulse(src - 4);
            if (exp == 0) begin exp = dv; nexp++; end
            else exp--;
            rchk("R4 count", b + 8'h04, 32'(exp));
          end
          rchk("R4 R11 pending", 8'h50, 32'((nexp > 0) << ch));
          bw(b + 8'h08, 32'((src << 2) | 1));
          pulse(src - 4);
          rchk("R3 hold", b + 8'h04, 32'(exp));
          bw(b + 8'h08, 32'((src << 2) | 3));
          pulse(src - 4);
          rchk("R3 illegal", b + 8'h04, 32'(exp));
        end
      end
    end
    bw(8'h4C, 32'h3);

    // R5 disabled sources
    bw(8'h00, 32'd5);
    for (int s = 0; s < 4; s++) begin
      bw(8'h08, 32'((s << 2) | 0));
      bw(8'h08, 32'((s << 2) | 2));
      for (int t = 0; t < 4; t++) pulse(t);
      rchk("R5 no source", 8'h04, 32'd5);
    end

    // R6 reload write does not touch count
    bw(8'h00, 32'd3);
    bw(8'h08, 32'h10);
    bw(8'h08, 32'h12);
    pulse(0);
    rchk("R6 step", 8'h04, 32'd2);
    bw(8'h00, 32'd9);
    rchk("R6 count kept", 8'h04, 32'd2);
    pulse(0); pulse(0);
    rchk("R6 zero", 8'h04, 32'd0);
    pulse(0);
    rchk("R6 new reload", 8'h04, 32'd9);
    rchk("R4 pending0", 8'h50, 32'h1);

    // R8 mask and output
    chk("R8 irq masked off", 32'(irq), 0);
    rchk("R8 masked zero", 8'h54, 0);
    bw(8'h48, 32'h1);
    #1 chk("R8 irq on", 32'(irq), 1);
    rchk("R8 masked", 8'h54, 32'h1);
    bw(8'h48, 32'h2);
    #1 chk("R8 irq other mask", 32'(irq), 0);
    bw(8'h48, 32'hFFFF_FFFF);
    rchk("R8 mask readback", 8'h48, 32'h3);
    #1 chk("R8 irq both", 32'(irq), 1);

    // R7 acknowledge
    bw(8'h4C, 32'h2);
    rchk("R7 other bit kept", 8'h50, 32'h1);
    bw(8'h4C, 32'h1);
    rchk("R7 cleared", 8'h50, 0);
    #1 chk("R7 irq low", 32'(irq), 0);
    rchk("R7 ack reads 0", 8'h4C, 0);

    // R9 expiry beats same-cycle ack; R7 not persistent
    bw(8'h00, 32'd0);
    bw(8'h08, 32'h10);
    bw(8'h08, 32'h12);
    @(negedge clk);
    ticks[0] = 1'b1; req = 1; we = 1; addr = 8'h4C; wdata = 32'h1;
    @(negedge clk);
    ticks = '0; req = 0; we = 0;
    rchk("R9 expiry wins", 8'h50, 32'h1);
    bw(8'h4C, 32'h1);
    rchk("R9 then cleared", 8'h50, 0);
    pulse(0);
    rchk("R7 re-set after ack", 8'h50, 32'h1);
    #1 chk("R8 irq re-raised", 32'(irq), 1);

    // R11 channel 1 pending while channel 0 untouched
    bw(8'h10, 32'd0);
    bw(8'h18, 32'h1C);
    bw(8'h18, 32'h1E);
    bw(8'h4C, 32'h1);
    pulse(3);
    rchk("R11 only ch1", 8'h50, 32'h2);
    rchk("R11 ch0 count", 8'h04, 0);

    // R1 reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1 chk("R1 irq in reset", 32'(irq), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    rchk("R1 raw after", 8'h50, 0);
    rchk("R1 mask after", 8'h48, 0);
    rchk("R1 div1 after", 8'h10, 0);
    pulse(3);
    rchk("R1 stopped", 8'h14, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule